// File: doc/BRIEF.md
# Virtual Segment Decoder and Privilege Check

This block sits in front of address translation. Each cycle it may accept a 64-bit virtual address, the privilege of the current mode and the kind of access, either load or store. It works out which address segment the address falls in and the lowest privilege that may use that segment. It then decides whether the address maps straight to a physical address or has to go through the translation buffer.

For direct-mapped addresses it produces the physical address itself. It raises an address-error fault, with a load code or a store code, on three conditions:
- the current privilege is too low for the segment;
- a mapped address lies beyond the virtual range;
- a direct physical address lies beyond the physical range.

A second, independent input path takes the physical address that translation later returns and applies the same physical range check to it. Both paths register their results, so every answer appears one clock after its request.

Top module: `vseg_check`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `out_valid`, `out_mapped`, `out_pa`, `out_fault` and `ret_fault` are all zero.
- R2: Privilege codes are 0 = user, 1 = supervisor and 2 = kernel; code 3 ranks at or above kernel. If `req_priv` is below the segment's required level, `out_fault` is 2'b01 for a load (`req_store`=0) or 2'b10 for a store (`req_store`=1). A value of 2'b00 means no fault.
- R3: Addresses with bits 63..62 = 00 are mapped and need user level. Addresses with bits 63..62 = 01 are mapped and need supervisor level. Without a fault, `out_mapped`=1 and `out_pa`=0.
- R4: Addresses with bits 63..62 = 10 need kernel level and are direct-mapped. `out_pa` is bits 58..0 zero-extended, and bits 61..59 have no effect on it.
- R5: With bits 63..62 = 11 and bits 61..31 all ones (compatibility window), bits 30..29 pick the sub-segment:
  - 11 is mapped and needs kernel level;
  - 10 is mapped and needs supervisor level;
  - 01 and 00 are direct-mapped, need kernel level, and give `out_pa` = bits 28..0 zero-extended.
- R6: With bits 63..62 = 11 and bits 61..31 not all ones, the address is mapped and needs kernel level.
- R7: A mapped address whose bits 61..31 are not all ones faults (code as in R2) when bits 61..0 exceed 2^VA_BITS-1. Mapped addresses in the compatibility window are never range-checked.
- R8: A direct-mapped address faults (code as in R2) when its physical address exceeds 2^PA_BITS-1. A value equal to that limit passes.
- R9: When `ret_valid` is high, `ret_fault` shows one cycle later whether `ret_pa` exceeds 2^PA_BITS-1: 2'b01 for a load, 2'b10 for a store (`ret_store`), and 2'b00 if within range.
- R10: All outputs are registered. A request sampled at one rising edge is reported after that edge with `out_valid`=1. A cycle without a request gives `out_valid`=0 with `out_mapped`, `out_pa` and `out_fault` at zero, and a cycle without `ret_valid` gives `ret_fault`=0.
- R11: Whenever `out_fault` is nonzero, `out_mapped` is 0 and `out_pa` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A virtual address is presented this cycle |
| req_vaddr | input | 64 | Virtual address to classify |
| req_priv | input | 2 | Current privilege level |
| req_store | input | 1 | 1 for a store access, 0 for a load |
| ret_valid | input | 1 | A translated physical address is presented |
| ret_pa | input | 64 | Physical address returned by translation |
| ret_store | input | 1 | Access type belonging to `ret_pa` |
| out_valid | output | 1 | Classification result is present |
| out_mapped | output | 1 | Address needs translation |
| out_pa | output | 64 | Physical address for direct-mapped accesses |
| out_fault | output | 2 | Address-error code for the request |
| ret_fault | output | 2 | Address-error code for the returned address |

## Verification
A wrong segment decode or a wrong required-level choice shows up as a bad `out_mapped`, `out_pa` or `out_fault` in the very cycle after the request. Nothing is held across requests, so an error cannot hide and reappear later. Each result depends only on the request just before it. For that reason the directed cases sit on the decision edges:
- each value of bits 30..29 inside the compatibility window and just outside it;
- the cache-mode bits of the direct segment;
- the last virtual and physical addresses inside the limits and the first ones beyond them.

A stale register would instead appear as a nonzero output in an idle cycle.

// File: rtl/vseg_pkg.sv
package vseg_pkg;

  localparam int VADDR_W = 64;

  localparam logic [1:0] PRIV_USER   = 2'd0;
  localparam logic [1:0] PRIV_SUPER  = 2'd1;
  localparam logic [1:0] PRIV_KERNEL = 2'd2;

  localparam logic [1:0] FLT_NONE  = 2'b00;
  localparam logic [1:0] FLT_LOAD  = 2'b01;
  localparam logic [1:0] FLT_STORE = 2'b10;

  typedef struct packed {
    logic [1:0]         need_priv;
    logic               direct;
    logic               compat;
    logic [VADDR_W-1:0] direct_pa;
  } seg_info_t;

  function automatic logic [1:0] fault_code(input logic is_store);
    return is_store ? FLT_STORE : FLT_LOAD;
  endfunction

endpackage

// File: rtl/vseg_classify.sv
module vseg_classify
  import vseg_pkg::*;
(
  input  logic [VADDR_W-1:0] vaddr,
  output seg_info_t          info
);

  logic in_compat;
  assign in_compat = &vaddr[61:31];

  always_comb begin
    info           = '0;
    info.compat    = in_compat;
    info.need_priv = PRIV_KERNEL;
    unique case (vaddr[63:62])
      2'b00: info.need_priv = PRIV_USER;
      2'b01: info.need_priv = PRIV_SUPER;
      2'b10: begin
        info.direct    = 1'b1;
        info.direct_pa = {5'b0, vaddr[58:0]};
      end
      default: begin
        if (in_compat) begin
          unique case (vaddr[30:29])
            2'b11: info.need_priv = PRIV_KERNEL;
            2'b10: info.need_priv = PRIV_SUPER;
            default: begin
              info.direct    = 1'b1;
              info.direct_pa = {35'b0, vaddr[28:0]};
            end
          endcase
        end
      end
    endcase
  end

endmodule

// File: rtl/vseg_limit.sv
module vseg_limit #(
  parameter int LIMIT_BITS = 40,
  parameter int CHECK_W    = 62
) (
  input  logic [CHECK_W-1:0] value,
  output logic               over
);

  localparam logic [CHECK_W-1:0] MAX_VAL =
    (LIMIT_BITS >= CHECK_W) ? {CHECK_W{1'b1}}
                            : ((CHECK_W'(1) << LIMIT_BITS) - CHECK_W'(1));

  assign over = (value > MAX_VAL);

endmodule

// File: rtl/vseg_check.sv
module vseg_check
  import vseg_pkg::*;
#(
  parameter int VA_BITS = 40,
  parameter int PA_BITS = 36
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [63:0] req_vaddr,
  input  logic [1:0]  req_priv,
  input  logic        req_store,
  input  logic        ret_valid,
  input  logic [63:0] ret_pa,
  input  logic        ret_store,
  output logic        out_valid,
  output logic        out_mapped,
  output logic [63:0] out_pa,
  output logic [1:0]  out_fault,
  output logic [1:0]  ret_fault
);

  seg_info_t info;
  logic      va_over, pa_over, ret_over;
  logic      priv_low, range_bad, any_fault;

  vseg_classify u_classify (
    .vaddr (req_vaddr),
    .info  (info)
  );

  vseg_limit #(.LIMIT_BITS(VA_BITS), .CHECK_W(62)) u_va_limit (
    .value (req_vaddr[61:0]),
    .over  (va_over)
  );

  vseg_limit #(.LIMIT_BITS(PA_BITS), .CHECK_W(VADDR_W)) u_pa_limit (
    .value (info.direct_pa),
    .over  (pa_over)
  );

  vseg_limit #(.LIMIT_BITS(PA_BITS), .CHECK_W(VADDR_W)) u_ret_limit (
    .value (ret_pa),
    .over  (ret_over)
  );

  always_comb begin
    priv_low  = (req_priv < info.need_priv);
    range_bad = info.direct ? pa_over : (!info.compat && va_over);
    any_fault = priv_low || range_bad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_mapped <= 1'b0;
      out_pa     <= '0;
      out_fault  <= FLT_NONE;
      ret_fault  <= FLT_NONE;
    end else begin
      out_valid  <= req_valid;
      out_mapped <= req_valid && !any_fault && !info.direct;
      out_pa     <= (req_valid && !any_fault && info.direct) ? info.direct_pa : '0;
      out_fault  <= (req_valid && any_fault) ? fault_code(req_store) : FLT_NONE;
      ret_fault  <= (ret_valid && ret_over) ? fault_code(ret_store) : FLT_NONE;
    end
  end

  // R11: a faulting result carries no mapping and no address
  assert_fault_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (out_fault != FLT_NONE) |-> (!out_mapped && out_pa == 64'd0));

  // R2: the fault code follows the access type of the request
  assert_code_type_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (out_fault == FLT_NONE ||
                   out_fault == ($past(req_store) ? FLT_STORE : FLT_LOAD)));

  // R2: user mode can never use the upper half of the space
  assert_user_upper_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_priv == PRIV_USER && req_vaddr[63]) |=> (out_fault != FLT_NONE));

  // R10: idle cycles produce an all-zero result
  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!out_valid && !out_mapped && out_pa == 64'd0 && out_fault == FLT_NONE));

  // R8: a direct address that is reported never exceeds the physical range
  assert_pa_in_range_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_mapped && out_fault == FLT_NONE) |-> ((out_pa >> PA_BITS) == 64'd0));

  // R9: an out-of-range returned address is always flagged
  assert_ret_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && ((ret_pa >> PA_BITS) != 64'd0)) |=> (ret_fault != FLT_NONE));

endmodule

// File: tb/vseg_check_bench.sv
module vseg_check_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_store, ret_valid, ret_store;
  logic [63:0] req_vaddr, ret_pa;
  logic [1:0]  req_priv;
  logic        out_valid, out_mapped;
  logic [63:0] out_pa;
  logic [1:0]  out_fault, ret_fault;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  vseg_check u_vseg_check (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_priv(req_priv), .req_store(req_store),
    .ret_valid(ret_valid), .ret_pa(ret_pa), .ret_store(ret_store),
    .out_valid(out_valid), .out_mapped(out_mapped), .out_pa(out_pa),
    .out_fault(out_fault), .ret_fault(ret_fault)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic req(input string tag, input logic [63:0] va, input logic [1:0] pv,
                     input logic st, input logic exp_map, input logic [63:0] exp_pa,
                     input logic [1:0] exp_flt);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_priv = pv; req_store = st;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"},  {63'd0, out_valid},  64'd1);
    chk({tag, " mapped"}, {63'd0, out_mapped}, {63'd0, exp_map});
    chk({tag, " pa"},     out_pa,              exp_pa);
    chk({tag, " fault"},  {62'd0, out_fault},  {62'd0, exp_flt});
  endtask

  task automatic ret(input string tag, input logic [63:0] pa, input logic st,
                     input logic [1:0] exp_flt);
    @(negedge clk);
    ret_valid = 1'b1; ret_pa = pa; ret_store = st;
    @(negedge clk);
    ret_valid = 1'b0;
    chk(tag, {62'd0, ret_fault}, {62'd0, exp_flt});
  endtask

  task automatic t_reset;
    chk("R1 valid",  {63'd0, out_valid},  64'd0);
    chk("R1 mapped", {63'd0, out_mapped}, 64'd0);
    chk("R1 pa",     out_pa,              64'd0);
    chk("R1 fault",  {62'd0, out_fault},  64'd0);
    chk("R1 ret",    {62'd0, ret_fault},  64'd0);
  endtask

  task automatic t_low_segments;
    req("R3 user seg user",   64'h0000_0012_3456_7000, 2'd0, 1'b0, 1'b1, 64'd0, 2'b00);
    req("R3 user seg kernel", 64'h0000_0012_3456_7000, 2'd2, 1'b1, 1'b1, 64'd0, 2'b00);
    req("R2 super seg user",  64'h4000_0000_0000_1000, 2'd0, 1'b0, 1'b0, 64'd0, 2'b01);
    req("R3 super seg super", 64'h4000_0000_0000_1000, 2'd1, 1'b0, 1'b1, 64'd0, 2'b00);
  endtask

  task automatic t_direct;
    req("R4 direct cache bits", 64'hB800_0000_1234_5678, 2'd2, 1'b0, 1'b0, 64'h1234_5678, 2'b00);
    req("R4 direct plain",      64'h8000_0000_1234_5678, 2'd2, 1'b0, 1'b0, 64'h1234_5678, 2'b00);
    req("R2 direct super st",   64'h8000_0000_1234_5678, 2'd1, 1'b1, 1'b0, 64'd0, 2'b10);
    req("R8 direct at limit",   64'h8000_000F_FFFF_FFFF, 2'd2, 1'b0, 1'b0, 64'hF_FFFF_FFFF, 2'b00);
    req("R8 direct over ld",    64'h8000_0010_0000_0000, 2'd2, 1'b0, 1'b0, 64'd0, 2'b01);
    req("R8 direct over st",    64'h8000_0010_0000_0000, 2'd3, 1'b1, 1'b0, 64'd0, 2'b10);
  endtask

  task automatic t_compat;
    req("R5 compat sub00",       64'hFFFF_FFFF_8000_1234, 2'd2, 1'b0, 1'b0, 64'h1234, 2'b00);
    req("R5 compat sub01",       64'hFFFF_FFFF_A000_0010, 2'd2, 1'b0, 1'b0, 64'h10, 2'b00);
    req("R2 compat sub01 user",  64'hFFFF_FFFF_A000_0010, 2'd0, 1'b0, 1'b0, 64'd0, 2'b01);
    req("R5 compat sub10 super", 64'hFFFF_FFFF_C000_0000, 2'd1, 1'b0, 1'b1, 64'd0, 2'b00);
    req("R5 compat sub11 super", 64'hFFFF_FFFF_E000_0000, 2'd1, 1'b1, 1'b0, 64'd0, 2'b10);
    req("R7 compat sub11 kern",  64'hFFFF_FFFF_E000_0000, 2'd2, 1'b0, 1'b1, 64'd0, 2'b00);
  endtask

  task automatic t_kernel_mapped;
    req("R6 kseg low kernel",  64'hC000_0000_0000_2000, 2'd2, 1'b0, 1'b1, 64'd0, 2'b00);
    req("R6 kseg low super",   64'hC000_0000_0000_2000, 2'd1, 1'b1, 1'b0, 64'd0, 2'b10);
    req("R7 kseg not compat",  64'hFFFF_FFFF_7FFF_F000, 2'd2, 1'b0, 1'b0, 64'd0, 2'b01);
  endtask

  task automatic t_va_limit;
    req("R7 user at limit", 64'h0000_00FF_FFFF_FFFF, 2'd0, 1'b0, 1'b1, 64'd0, 2'b00);
    req("R7 user over",     64'h0000_0100_0000_0000, 2'd0, 1'b1, 1'b0, 64'd0, 2'b10);
    req("R7 super over",    64'h4000_0100_0000_0000, 2'd1, 1'b0, 1'b0, 64'd0, 2'b01);
  endtask

  task automatic t_return;
    ret("R9 ret at limit", 64'h0000_000F_FFFF_FFFF, 1'b1, 2'b00);
    ret("R9 ret over st",  64'h0000_0010_0000_0000, 1'b1, 2'b10);
    ret("R9 ret over ld",  64'h8000_0000_0000_0000, 1'b0, 2'b01);
  endtask

  task automatic t_idle;
    req("R10 before idle", 64'h8000_0000_0000_0040, 2'd2, 1'b0, 1'b0, 64'h40, 2'b00);
    @(negedge clk);
    chk("R10 idle valid",  {63'd0, out_valid},  64'd0);
    chk("R10 idle pa",     out_pa,              64'd0);
    chk("R10 idle mapped", {63'd0, out_mapped}, 64'd0);
    chk("R10 idle ret",    {62'd0, ret_fault},  64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    req_valid = 1'b0; req_vaddr = '0; req_priv = 2'd0; req_store = 1'b0;
    ret_valid = 1'b0; ret_pa = '0; ret_store = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_low_segments;
    t_direct;
    t_compat;
    t_kernel_mapped;
    t_va_limit;
    t_return;
    t_idle;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule